// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block takes four level-sensitive PCI interrupt lines, numbered 0 to 3 for pins A to D, and steers each onto one of sixteen legacy ISA interrupt outputs. Each PCI line has its own byte-wide steering register. A value below 16 selects the ISA output with that number. A value of 16 or more cuts the line off completely. Several PCI lines may point at the same ISA output, and that output is then the wired-OR of all of them.

The steering bytes sit at configuration offsets 0x60 to 0x63, one per pin in pin order. Firmware writes and reads them through a byte-wide configuration port with separate write and read strobes. The block also publishes the resolved route of every pin, as an enable flag plus an ISA number, so that neighbouring logic can follow the current mapping. Every output comes from registered state. A change on a PCI line, or a rewrite of a steering byte, shows up on the ISA outputs one clock later, with all sixteen outputs worked out again.

Top module: `pirq_router`

## Requirements
- R1: After reset every steering byte holds 0x80, every route is disabled with route number 5'h1F, and all ISA outputs are low.
- R2: A write with the write strobe to offset 0x60+p (p = 0..3, pin A = 0) stores all 8 data bits in the steering byte of pin p, and a later read of that offset returns the byte unchanged.
- R3: When pin p's steering byte holds a value n below 16 and pin p is high, ISA output n is high one clock after the pin is sampled.
- R4: A steering byte of 16 (0x10) or more, including 0x80, disconnects its pin, so the pin drives no ISA output at any level.
- R5: Each ISA output is the OR of all pins currently steered to it. With two pins sharing one output, the output stays high while either pin is high and falls one clock after the last one drops.
- R6: Rewriting a steering byte takes effect one clock after the write. An asserted pin releases its old ISA output and drives the new one in that same cycle.
- R7: routeEn[p] is 1 and routeNum[5p+4:5p] equals the steering value when that value is below 16. Otherwise routeEn[p] is 0 and routeNum is 5'h1F. The route follows a write one clock later.
- R8: Writes to any offset outside 0x60 to 0x63 change no steering byte, route or output. Reads there return 0x00.
- R9: cfgRdData takes the addressed value one clock after a read strobe and holds it until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pciIrq | input | 4 | Level PCI interrupt lines, bit p is pin p (A = 0) |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWrData | input | 8 | Configuration write data |
| cfgWr | input | 1 | Write strobe |
| cfgRd | input | 1 | Read strobe |
| cfgRdData | output | 8 | Read data, valid one clock after cfgRd |
| isaIrq | output | 16 | ISA interrupt outputs, bit n is ISA IRQ n |
| routeEn | output | 4 | Per-pin route enable |
| routeNum | output | 20 | Per-pin ISA number, 5 bits per pin, 5'h1F when disabled |

## Verification
Any corruption of the level bitmap or of a steering byte appears on the ISA outputs no later than the clock after the next pin change or configuration write, because the bitmap is rebuilt from scratch every cycle. A steering byte that is wrong shows at once on the route outputs and on a read-back. The riskiest behaviours are the ones where stale state could linger: an asserted pin being re-steered or disabled, and a shared output with one contributor dropping. These cases are driven as directed cases and again at random, and each is compared cycle by cycle with a reference that recomputes the outputs from the written bytes.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int PIRQ_N     = 4;
  localparam int PIRQ_IDX_W = $clog2(PIRQ_N);

  // Strobes from the configuration decoder to the steering datapath
  typedef struct packed {
    logic [PIRQ_N-1:0]     wrSel;  // one-hot write select per pin
    logic                  rdStb;  // read strobe
    logic                  rdHit;  // read targets a steering byte
    logic [PIRQ_IDX_W-1:0] rdIdx;  // which steering byte is read
  } cfgStrobe_t;
endpackage

// File: rtl/pirq_cfg_ctrl.sv
module pirq_cfg_ctrl
  import pirq_router_pkg::*;
#(
  parameter logic [7:0] STEER_BASE = 8'h60
) (
  input  logic [7:0] cfgAddr,
  input  logic       cfgWr,
  input  logic       cfgRd,
  output cfgStrobe_t strb
);
  logic [7:0] offset;
  logic       inRange;

  always_comb begin
    offset  = cfgAddr - STEER_BASE;
    inRange = (cfgAddr >= STEER_BASE) && (offset < 8'(PIRQ_N));
    for (int p = 0; p < PIRQ_N; p++) begin
      strb.wrSel[p] = cfgWr && inRange && (offset[PIRQ_IDX_W-1:0] == PIRQ_IDX_W'(p));
    end
    strb.rdStb = cfgRd;
    strb.rdHit = inRange;
    strb.rdIdx = offset[PIRQ_IDX_W-1:0];
  end
endmodule

// File: rtl/pirq_steer_dp.sv
module pirq_steer_dp
  import pirq_router_pkg::*;
#(
  parameter int         ISA_N       = 16,
  parameter logic [7:0] STEER_RESET = 8'h80,
  localparam int        ISA_W       = $clog2(ISA_N),
  localparam int        NUM_W       = ISA_W + 1,
  localparam int        MAP_N       = ISA_N * PIRQ_N
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  cfgStrobe_t                strb,
  input  logic [7:0]                cfgWrData,
  input  logic [PIRQ_N-1:0]         pciIrq,
  output logic [7:0]                cfgRdData,
  output logic [ISA_N-1:0]          isaIrq,
  output logic [PIRQ_N-1:0]         routeEn,
  output logic [PIRQ_N*NUM_W-1:0]   routeNum
);
  logic [7:0]       steerReg  [PIRQ_N];
  logic [7:0]       steerNext [PIRQ_N];
  logic [MAP_N-1:0] levelMap;
  logic [MAP_N-1:0] levelNext;

  // Steering value after this cycle's write, so a rewrite lands in one clock
  always_comb begin
    for (int p = 0; p < PIRQ_N; p++) begin
      steerNext[p] = strb.wrSel[p] ? cfgWrData : steerReg[p];
    end
  end

  // Level bitmap rebuilt in full every cycle; bit (isa*PIRQ_N + pin)
  always_comb begin
    for (int i = 0; i < ISA_N; i++) begin
      for (int p = 0; p < PIRQ_N; p++) begin
        levelNext[i*PIRQ_N + p] = pciIrq[p] && (steerNext[p] == 8'(i));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < PIRQ_N; p++) steerReg[p] <= STEER_RESET;
      levelMap  <= '0;
      cfgRdData <= 8'h00;
    end else begin
      for (int p = 0; p < PIRQ_N; p++) steerReg[p] <= steerNext[p];
      levelMap <= levelNext;
      if (strb.rdStb) cfgRdData <= strb.rdHit ? steerReg[strb.rdIdx] : 8'h00;
    end
  end

  for (genvar i = 0; i < ISA_N; i++) begin : g_isa
    assign isaIrq[i] = |levelMap[i*PIRQ_N +: PIRQ_N];
  end

  for (genvar p = 0; p < PIRQ_N; p++) begin : g_route
    logic live;
    assign live                     = steerReg[p] < 8'(ISA_N);
    assign routeEn[p]               = live;
    assign routeNum[p*NUM_W +: NUM_W] = live ? {1'b0, steerReg[p][ISA_W-1:0]} : '1;
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter int         ISA_N       = 16,
  parameter logic [7:0] STEER_BASE  = 8'h60,
  parameter logic [7:0] STEER_RESET = 8'h80
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [PIRQ_N-1:0]                      pciIrq,
  input  logic [7:0]                             cfgAddr,
  input  logic [7:0]                             cfgWrData,
  input  logic                                   cfgWr,
  input  logic                                   cfgRd,
  output logic [7:0]                             cfgRdData,
  output logic [ISA_N-1:0]                       isaIrq,
  output logic [PIRQ_N-1:0]                      routeEn,
  output logic [PIRQ_N*($clog2(ISA_N)+1)-1:0]    routeNum
);
  cfgStrobe_t strb;

  pirq_cfg_ctrl #(.STEER_BASE(STEER_BASE)) u_ctrl (
    .cfgAddr (cfgAddr),
    .cfgWr   (cfgWr),
    .cfgRd   (cfgRd),
    .strb    (strb)
  );

  pirq_steer_dp #(.ISA_N(ISA_N), .STEER_RESET(STEER_RESET)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .cfgWrData (cfgWrData),
    .pciIrq    (pciIrq),
    .cfgRdData (cfgRdData),
    .isaIrq    (isaIrq),
    .routeEn   (routeEn),
    .routeNum  (routeNum)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
  import pirq_router_pkg::*;
#(
  parameter int         ISA_N      = 16,
  parameter logic [7:0] STEER_BASE = 8'h60,
  localparam int        NUM_W      = $clog2(ISA_N) + 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [PIRQ_N-1:0]         pciIrq,
  input logic [7:0]                cfgAddr,
  input logic [7:0]                cfgWrData,
  input logic                      cfgWr,
  input logic                      cfgRd,
  input logic [7:0]                cfgRdData,
  input logic [ISA_N-1:0]          isaIrq,
  input logic [PIRQ_N-1:0]         routeEn,
  input logic [PIRQ_N*NUM_W-1:0]   routeNum
);
  logic [PIRQ_N-1:0] pciSeen;
  logic [ISA_N-1:0]  expIsa;
  logic              outside;

  always_ff @(posedge clk) begin
    if (!rst_n) pciSeen <= '0;
    else        pciSeen <= pciIrq;
  end

  // Expected outputs from the published routes and last sampled pins
  always_comb begin
    expIsa = '0;
    for (int i = 0; i < ISA_N; i++) begin
      for (int p = 0; p < PIRQ_N; p++) begin
        if (routeEn[p] && pciSeen[p] && routeNum[p*NUM_W +: NUM_W] == NUM_W'(i))
          expIsa[i] = 1'b1;
      end
    end
    outside = (cfgAddr < STEER_BASE) || (8'(cfgAddr - STEER_BASE) >= 8'(PIRQ_N));
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (isaIrq == '0 && routeEn == '0));

  p_isa_or_routes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    isaIrq == expIsa);

  for (genvar p = 0; p < PIRQ_N; p++) begin : g_rt
    p_disabled_num_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !routeEn[p] |-> routeNum[p*NUM_W +: NUM_W] == '1);
  end

  p_outside_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWr && outside) |=> ($stable(routeEn) && $stable(routeNum)));

  p_outside_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgRd && outside) |=> cfgRdData == 8'h00);

  p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgRd |=> $stable(cfgRdData));
endmodule

bind pirq_router pirq_router_chk #(.ISA_N(ISA_N), .STEER_BASE(STEER_BASE)) u_chk (.*);

// File: tb/pirq_router_tb.sv
`timescale 1ns/1ps
module pirq_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pciIrq = '0;
  logic [7:0]  cfgAddr = '0;
  logic [7:0]  cfgWrData = '0;
  logic        cfgWr = 1'b0;
  logic        cfgRd = 1'b0;
  logic [7:0]  cfgRdData;
  logic [15:0] isaIrq;
  logic [3:0]  routeEn;
  logic [19:0] routeNum;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  logic [7:0] mSteer [4];
  logic [3:0] mPci;

  always #4 clk = ~clk;

  pirq_router u_dut (
    .clk(clk), .rst_n(rst_n), .pciIrq(pciIrq), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgWr(cfgWr), .cfgRd(cfgRd), .cfgRdData(cfgRdData),
    .isaIrq(isaIrq), .routeEn(routeEn), .routeNum(routeNum)
  );

  function automatic logic [15:0] modelIsa();
    logic [15:0] r = '0;
    for (int p = 0; p < 4; p++)
      if (mPci[p] && mSteer[p] < 8'd16) r[mSteer[p][3:0]] = 1'b1;
    return r;
  endfunction

  function automatic logic [5:0] modelRoute(int p);
    if (mSteer[p] < 8'd16) return {1'b1, 1'b0, mSteer[p][3:0]};
    return {1'b0, 5'h1F};
  endfunction

  function automatic bit inWin(logic [7:0] a);
    return a >= 8'h60 && a <= 8'h63;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    chk({req, " isa"}, 32'(isaIrq), 32'(modelIsa()));
    for (int p = 0; p < 4; p++)
      chk({req, " R7 route"}, 32'({routeEn[p], routeNum[p*5 +: 5]}), 32'(modelRoute(p)));
  endtask

  task automatic cfgWrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWrData = d; cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
    if (inWin(a)) mSteer[a - 8'h60] = d;
  endtask

  task automatic setPci(logic [3:0] v);
    @(negedge clk);
    pciIrq = v;
    @(negedge clk);
    mPci = v;
  endtask

  task automatic cfgRead(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfgAddr = a; cfgRd = 1'b1;
    @(negedge clk);
    cfgRd = 1'b0;
    d = cfgRdData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nErrors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] hold;
    void'($urandom(32'd4242));
    for (int p = 0; p < 4; p++) mSteer[p] = 8'h80;
    mPci = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkAll("R1");
    cfgRead(8'h60, rd); chk("R1 R2 readback", 32'(rd), 32'h80);

    // R2: full byte stored and read back
    cfgWrite(8'h63, 8'hA7);
    cfgRead(8'h63, rd); chk("R2 readback", 32'(rd), 32'hA7);
    checkAll("R4 wide value");

    // R3/R5: two pins share IRQ5
    cfgWrite(8'h60, 8'd5);
    cfgWrite(8'h61, 8'd5);
    setPci(4'b0011); checkAll("R3 R5 both high");
    chk("R5 bit5", 32'(isaIrq), 32'h0020);
    setPci(4'b0010); checkAll("R5 one dropped");
    chk("R5 still high", 32'(isaIrq[5]), 32'd1);
    setPci(4'b0000); checkAll("R5 last dropped");
    chk("R5 low", 32'(isaIrq), 32'h0);

    // R4: disable an asserted line with 0x80
    setPci(4'b0001);
    cfgWrite(8'h60, 8'h80); checkAll("R4 disable");
    chk("R4 quiet", 32'(isaIrq), 32'h0);

    // R6: re-steer an asserted line
    cfgWrite(8'h62, 8'd3);
    setPci(4'b0100); chk("R6 old", 32'(isaIrq), 32'h0008);
    cfgWrite(8'h62, 8'd9); chk("R6 moved", 32'(isaIrq), 32'h0200);
    checkAll("R6");

    // R4/R3 boundary: 16 disables, 15 drives
    cfgWrite(8'h62, 8'd16); chk("R4 sixteen", 32'(isaIrq), 32'h0);
    checkAll("R4 R7 sixteen");
    cfgWrite(8'h62, 8'd15); chk("R3 fifteen", 32'(isaIrq), 32'h8000);
    checkAll("R3 R7 fifteen");

    // R8: outside writes and reads
    cfgWrite(8'h64, 8'h01); checkAll("R8 write 0x64");
    cfgWrite(8'h5F, 8'h02); checkAll("R8 write 0x5F");
    cfgRead(8'h64, rd); chk("R8 read 0x64", 32'(rd), 32'h0);
    cfgRead(8'h5F, rd); chk("R8 read 0x5F", 32'(rd), 32'h0);

    // R9: read data holds without a strobe
    cfgRead(8'h62, rd); hold = rd;
    chk("R9 read", 32'(rd), 32'd15);
    cfgWrite(8'h62, 8'd7);
    repeat (3) @(negedge clk);
    chk("R9 hold", 32'(cfgRdData), 32'(hold));

    // Random mix
    for (int it = 0; it < 500; it++) begin
      int op = $urandom % 4;
      if (op == 0) begin
        setPci(4'($urandom));
        checkAll("R3 R5 random pins");
      end else if (op == 1) begin
        logic [7:0] v;
        int k = $urandom % 4;
        v = (k < 2) ? 8'($urandom % 16) : (k == 2) ? 8'h80 : 8'($urandom);
        cfgWrite(8'h60 + 8'($urandom % 4), v);
        checkAll("R6 R7 random steer");
      end else if (op == 2) begin
        logic [7:0] a = 8'($urandom);
        if (inWin(a)) a = 8'h70;
        cfgWrite(a, 8'($urandom));
        checkAll("R8 random outside");
      end else begin
        logic [7:0] a = 8'h5E + 8'($urandom % 8);
        cfgRead(a, rd);
        chk("R2 R8 random read", 32'(rd), inWin(a) ? 32'(mSteer[a - 8'h60]) : 32'h0);
      end
    end

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end
endmodule